// File: doc/BRIEF.md
# Output Compare Timer with Forced Compares

The block is a timer peripheral with one free-running 16-bit counter and five output-compare channels. A prescaler divides the system clock into counter ticks, and the counter advances once per tick. Each channel holds a compare value, a 2-bit pin action and a sticky status flag. When the counter steps onto a channel's compare value, the channel applies its pin action to its output pin and raises its flag.

Software can also trigger any channel's pin action early by writing a 1 to that channel's bit in a one-shot force register. A forced action waits for the next counter tick after the write. It changes the pin exactly as a real match would, but it never raises the status flag. The force register stores nothing and always reads back as zero. All registers are reached through a simple synchronous bus with an address, write data, a write strobe and combinational read data.

Top module: `ocf_timer`

## Requirements
- R1: The counter resets to 0x0000 and advances by one on every prescale tick. A tick occurs once every PRESCALE_DIV clocks. The counter wraps from 0xFFFF to 0x0000 and reads at address 0x0.
- R2: When a tick moves the counter onto channel n's compare value (address 0x8+n-1, reset value 0xFFFF), the pin action and the status flag take effect on that same clock edge.
- R3: The pin action is set by the control register at address 0x1, bits [2n-1:2n-2] for channel n. The encodings are 00 = hold, 01 = toggle, 10 = drive low and 11 = drive high.
- R4: The status register at address 0x2 holds one flag per channel, with bit n-1 for channel n. A flag stays set until a 1 is written to its bit. Writing 0 leaves it set.
- R5: The force register sits at address 0x3. Bit 7 is channel 1, bit 6 is channel 2 and so on down to bit 3 for channel 5. Bits 2..0 are unused, and the whole register always reads 0.
- R6: A 1 written to a force bit applies that channel's programmed pin action at the first tick edge strictly after the write edge. This holds even when the write edge is itself a tick edge.
- R7: A forced action never sets the channel's status flag.
- R8: Writing 0 to a force bit has no effect on that channel.
- R9: If a pending force and a real match land on the same tick, the action is applied once and the flag is set.
- R10: After reset, the pins, flags and control fields are 0 and every compare register reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | DATA_W (16) | Read data for bus_addr, combinational |
| oc_pin | output | NUM_CH (5) | Output-compare pins, bit n-1 for channel n |

## Verification
Three timing cases get the most attention, because a wrong design shows itself clearly in each:

- **Force write between ticks.** The bench writes a force on a clock that is not a tick. A design that acts during the write cycle changes the pin one cycle too early.
- **Force write on a tick edge.** The bench writes a force on the very edge where a tick occurs. A design that consumes the request on that same edge fires two cycles early, where it should wait a full prescale period.
- **Force and match together.** The bench lines up a pending force with a real match on one tick. A toggling pin that ends up unchanged shows the action was applied twice, and a clear flag shows the force masked the match.

Further checks cover the remaining behaviour:

- **Flags after a force.** A flag found set after a pure force, or left clear after a match, exposes a swapped flag source.
- **Counter wrap.** The counter is run through the 0xFFFF to 0x0000 wrap, with a compare value of zero, to show the match still fires at the wrap.

// File: rtl/ocf_pkg.sv
package ocf_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_HIGH   = 2'b11
   } oc_act_e;

   // Pin level after one compare event under action a
   function automatic logic act_result(input oc_act_e a, input logic cur);
      logic r;
      unique case (a)
         ACT_HOLD:   r = cur;
         ACT_TOGGLE: r = ~cur;
         ACT_LOW:    r = 1'b0;
         default:    r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ocf_prescale.sv
module ocf_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   initial begin
      assert (DIV >= 1) else $error("ocf_prescale: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_direct
         logic live_q;
         always_ff @(posedge clk) begin
            live_q <= !rst;
         end
         assign tick = live_q;
      end else begin : g_divide
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk) begin
            if (rst)               ph_q <= '0;
            else if (ph_q == LAST) ph_q <= '0;
            else                   ph_q <= ph_q + 1'b1;
         end
         assign tick = (ph_q == LAST);

         AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);  // R1
      end
   endgenerate

endmodule

// File: rtl/ocf_count.sv
module ocf_count #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt
);

   logic [W-1:0] cnt_q;

   assign cnt_nxt = cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (tick) cnt_q <= cnt_nxt;
   end

   assign cnt = cnt_q;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      tick |=> cnt_q == $past(cnt_q) + W'(1));  // R1
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt_q));  // R1

endmodule

// File: rtl/ocf_channel.sv
module ocf_channel
   import ocf_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic [W-1:0] cnt_nxt,
   input  logic [W-1:0] cmp,
   input  oc_act_e      act,
   input  logic         force_wr,
   input  logic         flag_clr,
   output logic         pin,
   output logic         flag
);

   logic pend_q;
   logic pin_q;
   logic flag_q;
   logic hit;
   logic fire;

   // A real match: this tick moves the counter onto the compare value
   assign hit  = tick && (cnt_nxt == cmp);
   // A pending force consumed on this tick, merged with a match so the action runs once
   assign fire = hit || (tick && pend_q);

   // A write wins over consumption, so a write on a tick edge waits for the next tick
   always_ff @(posedge clk) begin
      if (rst)           pend_q <= 1'b0;
      else if (force_wr) pend_q <= 1'b1;
      else if (tick)     pend_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst)       pin_q <= 1'b0;
      else if (fire) pin_q <= act_result(act, pin_q);
   end

   always_ff @(posedge clk) begin
      if (rst)           flag_q <= 1'b0;
      else if (hit)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign pin  = pin_q;
   assign flag = flag_q;

   AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q) |-> $past(tick && (cnt_nxt == cmp)));  // R7
   AST_PIN_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      !$stable(pin_q) |-> $past(tick));  // R6
   AST_HOLD_KEEPS_PIN: assert property (@(posedge clk) disable iff (rst)
      !$stable(pin_q) |-> $past(act) != ACT_HOLD);  // R3
   AST_FORCE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (pend_q && tick && act == ACT_HIGH) |=> pin_q);  // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag_q && !flag_clr) |=> flag_q);  // R4

endmodule

// File: rtl/ocf_timer.sv
module ocf_timer
   import ocf_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int NUM_CH       = 5,
   parameter int PRESCALE_DIV = 4,
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] oc_pin
);

   localparam int FORCE_MSB = 7;
   localparam logic [ADDR_W-1:0] A_CNT      = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_FLAG     = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_FORCE    = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_CMP_BASE = ADDR_W'(8);

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= 5) else $error("ocf_timer: NUM_CH must be 1..5");
      assert (DATA_W >= CNT_W && DATA_W >= 8) else $error("ocf_timer: DATA_W too narrow");
      assert (DATA_W >= 2 * NUM_CH) else $error("ocf_timer: control field does not fit");
      assert (ADDR_W >= 4) else $error("ocf_timer: ADDR_W must be at least 4");
   end

   logic              tick;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_nxt;
   logic [NUM_CH-1:0] flags;
   logic [NUM_CH-1:0] force_wr;
   logic [NUM_CH-1:0] flag_clr;
   oc_act_e           ctrl_q [NUM_CH];
   logic [CNT_W-1:0]  cmp_q  [NUM_CH];

   ocf_prescale #(.DIV(PRESCALE_DIV)) u_prescale (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   ocf_count #(.W(CNT_W)) u_count (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         localparam logic [ADDR_W-1:0] A_MY_CMP = A_CMP_BASE + ADDR_W'(i);

         assign force_wr[i] = bus_we && (bus_addr == A_FORCE) && bus_wdata[FORCE_MSB - i];
         assign flag_clr[i] = bus_we && (bus_addr == A_FLAG)  && bus_wdata[i];

         always_ff @(posedge clk) begin
            if (rst) begin
               ctrl_q[i] <= ACT_HOLD;
               cmp_q[i]  <= '1;
            end else if (bus_we) begin
               if (bus_addr == A_CTRL)   ctrl_q[i] <= oc_act_e'(bus_wdata[2*i +: 2]);
               if (bus_addr == A_MY_CMP) cmp_q[i]  <= bus_wdata[CNT_W-1:0];
            end
         end

         ocf_channel #(.W(CNT_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .cnt_nxt  (cnt_nxt),
            .cmp      (cmp_q[i]),
            .act      (ctrl_q[i]),
            .force_wr (force_wr[i]),
            .flag_clr (flag_clr[i]),
            .pin      (oc_pin[i]),
            .flag     (flags[i])
         );
      end
   endgenerate

   // Force address falls through to zero: the strobe register holds no state
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CNT) begin
         bus_rdata = DATA_W'(cnt);
      end else if (bus_addr == A_CTRL) begin
         for (int i = 0; i < NUM_CH; i++) bus_rdata[2*i +: 2] = ctrl_q[i];
      end else if (bus_addr == A_FLAG) begin
         bus_rdata[NUM_CH-1:0] = flags;
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == A_CMP_BASE + ADDR_W'(i)) bus_rdata = DATA_W'(cmp_q[i]);
      end
   end

   AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == A_FORCE) |-> (bus_rdata == '0));  // R5

endmodule

// File: tb/test_ocf_timer.sv
module test_ocf_timer;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_rdata;
   logic [4:0]  oc_pin;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   ocf_timer #(.PRESCALE_DIV(2)) i_ocf_timer (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .oc_pin    (oc_pin)
   );

   // Row: {channel[2:0], action[1:0], expected pins[4:0]}, each a real match
   localparam logic [9:0] VEC [10] = '{
      {3'd0, 2'b11, 5'b00001},
      {3'd0, 2'b01, 5'b00000},
      {3'd0, 2'b01, 5'b00001},
      {3'd0, 2'b00, 5'b00001},
      {3'd0, 2'b10, 5'b00000},
      {3'd1, 2'b11, 5'b00010},
      {3'd1, 2'b00, 5'b00010},
      {3'd4, 2'b01, 5'b10010},
      {3'd2, 2'b11, 5'b10110},
      {3'd1, 2'b10, 5'b10100}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   // Return at the negedge just after a tick edge
   task automatic align(output logic [15:0] v);
      logic [15:0] c0;
      logic [15:0] c1;
      rd(4'h0, c0);
      c1 = c0;
      while (c1 == c0) begin
         @(negedge clk);
         rd(4'h0, c1);
      end
      v = c1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [15:0] v;
      logic [15:0] ctrl_sh;
      ctrl_sh = '0;

      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R10 and R5: reset state
      rd(4'h0, d); check("R10 counter", d, 16'h0000);
      check("R10 pins", oc_pin, 5'b00000);
      rd(4'h2, d); check("R10 flags", d, 16'h0000);
      rd(4'h1, d); check("R10 control", d, 16'h0000);
      rd(4'h8, d); check("R10 compare1", d, 16'hFFFF);
      rd(4'hC, d); check("R10 compare5", d, 16'hFFFF);
      rd(4'h3, d); check("R5 force reads zero", d, 16'h0000);

      // R1: one increment every two clocks
      align(v);
      @(negedge clk); rd(4'h0, d); check("R1 no step between ticks", d, v);
      @(negedge clk); rd(4'h0, d); check("R1 step on tick", d, v + 16'd1);

      // R2, R3, R4: table of real matches
      for (int k = 0; k < 10; k++) begin
         logic [2:0]  ch;
         logic [15:0] target;
         ch = VEC[k][9:7];
         ctrl_sh[2*ch +: 2] = VEC[k][6:5];
         rd(4'h0, d);
         target = d + 16'd4;
         wr(4'h1, ctrl_sh);
         wr(4'h8 + {1'b0, ch}, target);
         rd(4'h0, d);
         while (d != target) begin
            @(negedge clk);
            rd(4'h0, d);
         end
         check($sformatf("R2 R3 row %0d pins", k), oc_pin, VEC[k][4:0]);
         rd(4'h2, d);
         check($sformatf("R2 row %0d flag", k), d[ch], 1'b1);
         wr(4'h2, 16'h001F);
         rd(4'h2, d);
         check($sformatf("R4 row %0d cleared", k), d, 16'h0000);
      end

      // R6, R7, R5: force written between ticks; ch1 toggle, ch2 high, ch3 low
      wr(4'h1, 16'h002D);
      align(v);
      wr(4'h3, 16'h00E7);
      check("R6 no action on write edge", oc_pin, 5'b10100);
      rd(4'h3, d); check("R5 force not stored", d, 16'h0000);
      @(negedge clk);
      check("R6 forced actions at next tick", oc_pin, 5'b10011);
      rd(4'h2, d); check("R7 force leaves flags clear", d, 16'h0000);

      // R6: force written on a tick edge waits a full period
      align(v);
      @(negedge clk);
      wr(4'h3, 16'h0080);
      check("R6 tick-edge write not applied", oc_pin, 5'b10011);
      @(negedge clk);
      check("R6 still pending", oc_pin, 5'b10011);
      @(negedge clk);
      check("R6 applied at following tick", oc_pin, 5'b10010);

      // R8: zero bits do nothing (ch1 toggle must stay put)
      align(v);
      wr(4'h3, 16'h0000);
      wr(4'h3, 16'h0040);
      repeat (6) @(negedge clk);
      check("R8 zero force bits ignored", oc_pin, 5'b10010);
      rd(4'h2, d); check("R8 flags untouched", d, 16'h0000);

      // R9: force pending on the same tick as a match on ch1 (toggle)
      align(v);
      wr(4'h8, v + 16'd2);
      wr(4'h3, 16'h0080);
      check("R9 not early", oc_pin, 5'b10010);
      @(negedge clk);
      check("R9 not before tick", oc_pin, 5'b10010);
      @(negedge clk);
      rd(4'h0, d); check("R9 counter at compare", d, v + 16'd2);
      check("R9 single toggle", oc_pin, 5'b10011);
      rd(4'h2, d); check("R9 flag from match", d, 16'h0001);

      // R4: writing 0 keeps flag, writing 1 clears
      wr(4'h2, 16'h0000);
      rd(4'h2, d); check("R4 zero write keeps flag", d, 16'h0001);
      wr(4'h2, 16'h0001);
      rd(4'h2, d); check("R4 one write clears flag", d, 16'h0000);

      // R1, R2: wrap with ch4 drive-high compare at zero
      wr(4'h1, 16'h00C0);
      wr(4'hB, 16'h0000);
      rd(4'h0, d);
      while (d != 16'hFFFF) begin
         @(negedge clk);
         rd(4'h0, d);
      end
      check("R2 no action before wrap", oc_pin, 5'b10011);
      align(v);
      check("R1 wrap to zero", v, 16'h0000);
      check("R2 match at zero", oc_pin, 5'b11011);
      rd(4'h2, d); check("R2 flag at zero", d, 16'h0008);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule